// File: doc/BRIEF.md
# Transmit Buffer Window Selector

This block keeps three transmit message buffers and shows exactly one of them to software through a shared register window on a small byte-wide register bus. Which buffer appears in the window is set by a 3-bit select register. Any pattern may be written to it, and the lowest set bit decides the buffer. A read of the select register returns that lowest set bit alone, as a one-hot value.

A flag register holds one "buffer free" bit per buffer. To claim the next free buffer, software reads the flag register and writes the value it read straight into the select register. Software hands a loaded buffer to the transmitter by writing 1 to its flag bit, which clears the bit. The transmitter sets the bit again with a one-cycle done pulse when it has finished with the buffer. While the mapped buffer's flag is clear, the buffer is queued for transmission and the window refuses it. When no select bit is set, no buffer is mapped at all. A separate read port gives the transmitter direct access to any byte of any buffer.

Initialization mode is signalled by a request input and an acknowledge input. When both are high, the select register is held at zero. When either is high, writes to the select register and to the flag register are ignored.

Top module: `tx_window_sel`

## Requirements
- R1: After reset the flag register reads 0x07 (all buffers free), the select register reads 0x00, and window reads return 0x00.
- R2: A read of the select register (address 0x01) returns a one-hot byte that holds only the lowest set bit of the stored value. Bits 7..3 always read 0. For example, 0x06 reads back as 0x02 and 0xFF reads back as 0x01.
- R3: The lowest set bit of the select value picks the mapped buffer: bit n maps buffer n. For example, 0x03 maps buffer 0 and 0x06 maps buffer 1. Window address 0x10+k reaches byte k (0..12) of the mapped buffer. A new select value applies from the next bus access.
- R4: With select value zero, window reads return 0x00 and window writes change no buffer.
- R5: Writing the flag register (address 0x00) clears each flag bit whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R6: While the mapped buffer's flag is 0, window reads return 0x00 and window writes are discarded. Access returns once the flag is set again.
- R7: A pulse on tx_done[n] sets flag n. If that pulse falls in the same cycle as a flag write that clears bit n, the flag ends up set.
- R8: While init_req and init_ack are both 1, the select register is forced to zero. While either of them is 1, writes to the select register and to the flag register are ignored.
- R9: Window offsets 13..15 (addresses 0x1D..0x1F) read 0x00, and writes to them change no buffer byte.
- R10: The transmitter port returns byte tx_rd_ofs of buffer tx_rd_buf with no extra latency, whatever the selection and flag state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| bus_addr | input | 5 | Register address: 0x00 flags, 0x01 select, 0x10..0x1F window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, zero when bus_rd is low) |
| tx_done | input | 3 | Per-buffer done pulse from the transmitter; sets the flag |
| tx_empty | output | 3 | Current buffer-free flags |
| tx_rd_buf | input | 2 | Transmitter read port: buffer number |
| tx_rd_ofs | input | 4 | Transmitter read port: byte offset |
| tx_rd_data | output | 8 | Transmitter read port: byte value |

## Verification
In one cycle, a software write to the flag register can clear a bit while the transmitter's done pulse sets the same bit. The bench first drives a flag write to clear buffer 0. It then drives a second flag write with data 0x03 at the same falling edge as a tx_done pulse on buffer 0. The flags must read 0x05 afterwards: bit 0 restored by the pulse, and bit 1 cleared by the write. A window write that lands in the cycle its buffer's done pulse arrives is judged against the flag value before that edge, so the write is refused. The bench checks this through the transmitter read port.

// File: rtl/txwin_pkg.sv
package txwin_pkg;

    localparam int NUM_BUF   = 3;
    localparam int BUF_BYTES = 13;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int OFS_W     = 4;

    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_SEL   = 5'h01;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_FLAGS,
        REG_SEL,
        REG_WIN
    } regdec_t;

    function automatic regdec_t decode_addr(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1])
            return REG_WIN;
        else if (a == ADDR_FLAGS)
            return REG_FLAGS;
        else if (a == ADDR_SEL)
            return REG_SEL;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/txwin_select.sv
module txwin_select #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_req,
    input  logic          init_ack,
    input  logic          wr_en,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  sel_onehot,
    output logic [IW-1:0] sel_idx,
    output logic          sel_valid
);

    logic [N-1:0] raw_q;
    logic         in_init;
    logic         locked;

    assign in_init = init_req && init_ack;
    assign locked  = init_req || init_ack;

    always_ff @(posedge clk) begin
        if (rst || in_init)
            raw_q <= '0;
        else if (wr_en && !locked)
            raw_q <= wdata;
    end

    // Scan from the top down so the lowest set bit is the last one kept.
    always_comb begin
        sel_onehot = '0;
        sel_idx    = '0;
        sel_valid  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (raw_q[i]) begin
                sel_onehot    = '0;
                sel_onehot[i] = 1'b1;
                sel_idx       = IW'(i);
                sel_valid     = 1'b1;
            end
        end
    end

    a_r8_init_forces_zero: assert property (@(posedge clk) disable iff (rst)
        in_init |=> (raw_q == '0));

    a_r8_write_locked: assert property (@(posedge clk) disable iff (rst)
        (locked && !in_init) |=> $stable(raw_q));

endmodule

// File: rtl/txwin_flags.sv
module txwin_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_req,
    input  logic         init_ack,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] done,
    output logic [N-1:0] empty
);

    logic         clr_en;
    logic [N-1:0] empty_d;

    assign clr_en = clr_wr && !init_req && !init_ack;

    // A done pulse is applied after the clear, so it wins a same-cycle collision.
    always_comb begin
        empty_d = empty;
        if (clr_en)
            empty_d = empty_d & ~clr_mask;
        empty_d = empty_d | done;
    end

    always_ff @(posedge clk) begin
        if (rst)
            empty <= '1;
        else
            empty <= empty_d;
    end

    a_r7_done_sets: assert property (@(posedge clk) disable iff (rst)
        (|done) |=> ((empty & $past(done)) == $past(done)));

    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((empty & $past(empty)) == $past(empty)));

endmodule

// File: rtl/txwin_bufmem.sv
module txwin_bufmem #(
    parameter int N     = 3,
    parameter int BYTES = 13,
    parameter int DW    = 8,
    parameter int OW    = 4,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_buf,
    input  logic [OW-1:0] wr_ofs,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] win_buf,
    input  logic [OW-1:0] win_ofs,
    output logic [DW-1:0] win_data,
    input  logic [IW-1:0] tx_buf,
    input  logic [OW-1:0] tx_ofs,
    output logic [DW-1:0] tx_data
);

    wire [N-1:0][BYTES-1:0][DW-1:0] mem_flat;

    for (genvar b = 0; b < N; b++) begin : g_buf
        for (genvar y = 0; y < BYTES; y++) begin : g_byte
            logic [DW-1:0] cell_q;
            logic          hit;

            assign hit = wr_en && (wr_buf == IW'(b)) && (wr_ofs == OW'(y));

            always_ff @(posedge clk) begin
                if (rst)
                    cell_q <= '0;
                else if (hit)
                    cell_q <= wr_data;
            end

            assign mem_flat[b][y] = cell_q;
        end
    end

    always_comb begin
        win_data = '0;
        if ((32'(win_buf) < N) && (32'(win_ofs) < BYTES))
            win_data = mem_flat[win_buf][win_ofs];
    end

    always_comb begin
        tx_data = '0;
        if ((32'(tx_buf) < N) && (32'(tx_ofs) < BYTES))
            tx_data = mem_flat[tx_buf][tx_ofs];
    end

    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_flat));

endmodule

// File: rtl/tx_window_sel.sv
module tx_window_sel
    import txwin_pkg::*;
#(
    parameter int NB    = txwin_pkg::NUM_BUF,
    parameter int BYTES = txwin_pkg::BUF_BYTES,
    parameter int DW    = txwin_pkg::DATA_W,
    parameter int AW    = txwin_pkg::ADDR_W,
    parameter int OW    = txwin_pkg::OFS_W,
    localparam int IW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_req,
    input  logic          init_ack,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NB-1:0] tx_done,
    output logic [NB-1:0] tx_empty,
    input  logic [IW-1:0] tx_rd_buf,
    input  logic [OW-1:0] tx_rd_ofs,
    output logic [DW-1:0] tx_rd_data
);

    regdec_t       dec;
    logic [NB-1:0] sel_onehot;
    logic [IW-1:0] sel_idx;
    logic          sel_valid;
    logic [OW-1:0] win_ofs;
    logic          ofs_ok;
    logic          buf_free;
    logic          win_ok;
    logic [DW-1:0] win_data;

    assign dec     = decode_addr(bus_addr);
    assign win_ofs = bus_addr[OW-1:0];
    assign ofs_ok  = 32'(win_ofs) < BYTES;

    always_comb begin
        buf_free = 1'b0;
        if (32'(sel_idx) < NB)
            buf_free = tx_empty[sel_idx];
    end

    assign win_ok = sel_valid && buf_free && ofs_ok;

    txwin_select #(.N(NB)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .init_req  (init_req),
        .init_ack  (init_ack),
        .wr_en     (bus_wr && (dec == REG_SEL)),
        .wdata     (bus_wdata[NB-1:0]),
        .sel_onehot(sel_onehot),
        .sel_idx   (sel_idx),
        .sel_valid (sel_valid)
    );

    txwin_flags #(.N(NB)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .init_req(init_req),
        .init_ack(init_ack),
        .clr_wr  (bus_wr && (dec == REG_FLAGS)),
        .clr_mask(bus_wdata[NB-1:0]),
        .done    (tx_done),
        .empty   (tx_empty)
    );

    txwin_bufmem #(.N(NB), .BYTES(BYTES), .DW(DW), .OW(OW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr && (dec == REG_WIN) && win_ok),
        .wr_buf  (sel_idx),
        .wr_ofs  (win_ofs),
        .wr_data (bus_wdata),
        .win_buf (sel_idx),
        .win_ofs (win_ofs),
        .win_data(win_data),
        .tx_buf  (tx_rd_buf),
        .tx_ofs  (tx_rd_ofs),
        .tx_data (tx_rd_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (dec)
                REG_FLAGS: bus_rdata = {{(DW-NB){1'b0}}, tx_empty};
                REG_SEL:   bus_rdata = {{(DW-NB){1'b0}}, sel_onehot};
                REG_WIN:   bus_rdata = win_ok ? win_data : '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    a_r2_sel_read_onehot: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec == REG_SEL) |-> $onehot0(bus_rdata));

    a_r4_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec == REG_WIN && !sel_valid) |-> (bus_rdata == '0));

    a_r6_blocked_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec == REG_WIN && sel_valid && !buf_free) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_tx_window_sel.sv
`timescale 1ns/1ps
module sim_tx_window_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_req = 1'b0;
    logic       init_ack = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] tx_done = '0;
    logic [2:0] tx_empty;
    logic [1:0] tx_rd_buf = '0;
    logic [3:0] tx_rd_ofs = '0;
    logic [7:0] tx_rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_mem [3][13];

    always #10 clk = ~clk;

    tx_window_sel u0 (
        .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_done(tx_done), .tx_empty(tx_empty),
        .tx_rd_buf(tx_rd_buf), .tx_rd_ofs(tx_rd_ofs), .tx_rd_data(tx_rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic txrd(input int b, input int o, output logic [7:0] d);
        @(negedge clk);
        tx_rd_buf = 2'(b); tx_rd_ofs = 4'(o);
        #2;
        d = tx_rd_data;
    endtask

    task automatic pulse_done(input logic [2:0] m);
        @(negedge clk);
        tx_done = m;
        @(negedge clk);
        tx_done = '0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(5'h00, v); chk("R1 flags after reset", v, 8'h07);
        rd(5'h01, v); chk("R1 select after reset", v, 8'h00);
        rd(5'h10, v); chk("R1 window after reset", v, 8'h00);
    endtask

    task automatic t_select_readback;
        logic [7:0] v;
        wr(5'h01, 8'h06); rd(5'h01, v); chk("R2 select 0x06 readback", v, 8'h02);
        wr(5'h01, 8'h07); rd(5'h01, v); chk("R2 select 0x07 readback", v, 8'h01);
        wr(5'h01, 8'h04); rd(5'h01, v); chk("R2 select 0x04 readback", v, 8'h04);
        wr(5'h01, 8'hFF); rd(5'h01, v); chk("R2 select 0xFF readback", v, 8'h01);
        wr(5'h01, 8'hF8); rd(5'h01, v); chk("R2 upper bits only readback", v, 8'h00);
    endtask

    task automatic t_window_map;
        logic [7:0] v;
        for (int b = 0; b < 3; b++) begin
            wr(5'h01, 8'(1 << b));
            for (int o = 0; o < 13; o += 4) begin
                logic [7:0] d;
                d = 8'((b << 4) | o | 8'h80);
                wr(5'(16 + o), d);
                exp_mem[b][o] = d;
            end
            wr(5'h1C, 8'(8'h40 | b));
            exp_mem[b][12] = 8'(8'h40 | b);
        end
        wr(5'h01, 8'h03); rd(5'h14, v); chk("R3 sel 0x03 maps buffer 0", v, exp_mem[0][4]);
        wr(5'h01, 8'h06); rd(5'h14, v); chk("R3 sel 0x06 maps buffer 1", v, exp_mem[1][4]);
        wr(5'h01, 8'h04); rd(5'h1C, v); chk("R3 sel 0x04 maps buffer 2", v, exp_mem[2][12]);
        for (int b = 0; b < 3; b++) begin
            txrd(b, 8, v); chk("R10 tx port byte 8", v, exp_mem[b][8]);
            txrd(b, 12, v); chk("R10 tx port byte 12", v, exp_mem[b][12]);
        end
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        wr(5'h01, 8'h00);
        rd(5'h10, v); chk("R4 unmapped read", v, 8'h00);
        wr(5'h13, 8'hAA);
        wr(5'h10, 8'h55);
        for (int b = 0; b < 3; b++) begin
            txrd(b, 3, v); chk("R4 unmapped write byte 3", v, exp_mem[b][3]);
            txrd(b, 0, v); chk("R4 unmapped write byte 0", v, exp_mem[b][0]);
        end
    endtask

    task automatic t_offset_range;
        logic [7:0] v;
        wr(5'h01, 8'h01);
        wr(5'h1D, 8'h5A);
        rd(5'h1D, v); chk("R9 offset 13 read", v, 8'h00);
        rd(5'h1F, v); chk("R9 offset 15 read", v, 8'h00);
        for (int o = 0; o < 13; o++) begin
            txrd(0, o, v); chk("R9 offset 13 write leaves bytes", v, exp_mem[0][o]);
        end
    endtask

    task automatic t_flags;
        logic [7:0] v;
        wr(5'h00, 8'h02); rd(5'h00, v); chk("R5 clear bit1", v, 8'h05);
        wr(5'h00, 8'h00); rd(5'h00, v); chk("R5 zero write no effect", v, 8'h05);
        pulse_done(3'b010); rd(5'h00, v); chk("R7 done sets bit1", v, 8'h07);
    endtask

    task automatic t_blocked;
        logic [7:0] v;
        wr(5'h00, 8'h02);
        wr(5'h01, 8'h02);
        rd(5'h14, v); chk("R6 blocked read", v, 8'h00);
        wr(5'h14, 8'hEE);
        txrd(1, 4, v); chk("R6 blocked write discarded", v, exp_mem[1][4]);
        wr(5'h01, 8'h06);
        rd(5'h1C, v); chk("R6 lowest bit blocked, no fallback", v, 8'h00);
        // window write in the same cycle as the done pulse: judged on old flag
        @(negedge clk);
        bus_addr = 5'h18; bus_wdata = 8'h33; bus_wr = 1'b1; tx_done = 3'b010;
        @(negedge clk);
        bus_wr = 1'b0; tx_done = '0;
        txrd(1, 8, v); chk("R6 write beside done pulse refused", v, exp_mem[1][8]);
        rd(5'h14, v); chk("R6 access restored after done", v, exp_mem[1][4]);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        wr(5'h00, 8'h01);
        rd(5'h00, v); chk("R5 clear bit0", v, 8'h06);
        @(negedge clk);
        bus_addr = 5'h00; bus_wdata = 8'h03; bus_wr = 1'b1; tx_done = 3'b001;
        @(negedge clk);
        bus_wr = 1'b0; tx_done = '0;
        rd(5'h00, v); chk("R7 done wins over same-cycle clear", v, 8'h05);
        pulse_done(3'b010);
        rd(5'h00, v); chk("R7 flags restored", v, 8'h07);
    endtask

    task automatic t_init;
        logic [7:0] v;
        wr(5'h01, 8'h04);
        @(negedge clk); init_req = 1'b1;
        wr(5'h01, 8'h01); rd(5'h01, v); chk("R8 select locked by request", v, 8'h04);
        wr(5'h00, 8'h01); rd(5'h00, v); chk("R8 flags locked by request", v, 8'h07);
        @(negedge clk); init_req = 1'b0; init_ack = 1'b1;
        wr(5'h00, 8'h02); rd(5'h00, v); chk("R8 flags locked by ack", v, 8'h07);
        @(negedge clk); init_req = 1'b1;
        @(negedge clk);
        rd(5'h01, v); chk("R8 select forced zero", v, 8'h00);
        wr(5'h01, 8'h02); rd(5'h01, v); chk("R8 select write in init", v, 8'h00);
        @(negedge clk); init_req = 1'b0; init_ack = 1'b0;
        rd(5'h01, v); chk("R8 select zero after init", v, 8'h00);
        wr(5'h01, 8'h02); rd(5'h01, v); chk("R8 select writable again", v, 8'h02);
    endtask

    initial begin
        for (int b = 0; b < 3; b++)
            for (int o = 0; o < 13; o++)
                exp_mem[b][o] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_select_readback();
        t_window_map();
        t_unmapped();
        t_offset_range();
        t_flags();
        t_blocked();
        t_collision();
        t_init();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule